// File: doc/BRIEF.md
# DVFS Clock Change Sequencer

This block walks a CPU clock domain from one performance level to another. A request names the level the domain is running at and the level it must move to. Level 0 is the fastest of 24 levels (2.5 GHz) and each higher index is 100 MHz slower, down to 200 MHz at index 23. For every level the block holds a PLL setting, made of a feedback multiplier M, a reference pre-divider P and a post-divider shift S, and two divider words for the domain's clock dividers.

The sequencer drives write strobes towards the divider block, the clock source mux and the PLL, and waits on their status after each write. When two levels share M and P, only S is rewritten. Otherwise the PLL is relocked: the domain is parked on a backup bus clock, the PLL is reprogrammed, an internal lock-time counter runs, and the domain is switched back. A faster target gets its dividers before the PLL changes. A slower target gets them after. Every status wait is bounded by a timeout limit supplied at the port. When that limit expires, the sequence is abandoned and an error flag is set.

Top module: `dvfs_seq`

## Requirements
- R1: After reset `req_ready` is 1, `done` and `err` are 0 and no write strobe is active.
- R2: A request whose two indices are equal issues no write strobe and raises `done` for one cycle.
- R3: When M and P of the two levels match, no mux write and no full PLL write occur. A single `pll_s_we` strobe is issued with the new level's S in `pll_cfg[2:0]`. `pll_cfg` packs M in bits 18:9, P in bits 8:3 and S in bits 2:0.
- R4: Moving to a lower index (faster), the new level's divider words are written before any PLL write.
- R5: Moving to a higher index (slower), the PLL write comes first and the new level's divider words are written last.
- R6: Applying dividers writes `diva_data`, then waits until all six bits of `diva_busy` are 0, then writes `divb_data` and waits until both bits of `divb_busy` are 0.
  - `diva_data` holds six 3-bit fields, lowest first: core 1 = 0, core 2 = 0, bus clock = 4 for levels 0 to 9, 3 for levels 10 to 13 and 2 above, then three fields of 7.
  - `divb_data` holds the PLL-side divider = 0 in bits 2:0 and the monitor divider in bits 5:3: 5, 4 or 3 over the same three bands.
  - The divider block raises busy in the cycle after the strobe.
- R7: A relock issues these steps in order:
  1. A mux write with `mux_to_pll`=0, after which the sequencer waits for `mux_status`=2.
  2. A `pll_we` strobe carrying the full new M/P/S.
  3. A wait for lock.
  4. A mux write with `mux_to_pll`=1, after which the sequencer waits for `mux_status`=1.
- R8: If both indices are below 17 during a relock, level 17's dividers are applied before the backup mux write and the new level's dividers are applied after the return to the PLL.
- R9: The mux write back to the PLL occurs exactly P×150+2 cycles after the `pll_we` strobe, where P is the new level's P.
- R10: `req_ready` is 1 only while idle. Requests presented while a sequence runs are ignored.
- R11: `done` is a one-cycle pulse raised together with `req_ready` once the last step of a sequence finishes.
- R12: A status wait that lasts past `tmo_limit` cycles sets `err`. The sequencer then returns to idle, with no further strobe and no `done`. `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_old | input | 5 | Current level index |
| req_new | input | 5 | Target level index |
| tmo_limit | input | 16 | Timeout limit for each status wait, in cycles |
| diva_we | output | 1 | Write strobe, divider group A |
| diva_data | output | 18 | Divider group A word |
| diva_busy | input | 6 | Divider group A busy flags |
| divb_we | output | 1 | Write strobe, divider group B |
| divb_data | output | 6 | Divider group B word |
| divb_busy | input | 2 | Divider group B busy flags |
| mux_we | output | 1 | Clock source mux write strobe |
| mux_to_pll | output | 1 | Mux target: 1 PLL, 0 backup bus clock |
| mux_status | input | 2 | Mux status code: 1 on PLL, 2 on backup, 0 switching |
| pll_we | output | 1 | Full M/P/S write strobe |
| pll_s_we | output | 1 | S-only write strobe |
| pll_cfg | output | 19 | M/P/S of the target level |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Sticky timeout error |

## Verification
The hardest situation to reach is the safe-divider bracket. It needs a relock between two levels that both lie below 17 and whose M/P pairs differ, with the step order depending on direction. Directed pairs such as 5↔3 cover both directions. Random index pairs also hit S-only groups like 1/13/19/22 and relocks out of level 17, where no bracket is applied. Timeout is reached in two ways: by setting the limit below the lock count of a relock, and by a mux responder that never reports its target code.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    localparam int NUM_LVL   = 24;
    localparam int LVL_IDX_W = $clog2(NUM_LVL);
    localparam int M_W       = 10;
    localparam int P_W       = 6;
    localparam int S_W       = 3;
    localparam int PMS_W     = M_W + P_W + S_W;
    localparam int DF_W      = 3;
    localparam int DIVA_N    = 6;
    localparam int DIVB_N    = 2;
    localparam int DIVA_W    = DF_W * DIVA_N;
    localparam int DIVB_W    = DF_W * DIVB_N;

    localparam logic [1:0] MUX_CODE_PLL = 2'd1;
    localparam logic [1:0] MUX_CODE_BUS = 2'd2;

    typedef logic [LVL_IDX_W-1:0] lvl_idx_t;
    typedef logic [PMS_W-1:0]     pms_t;

    function automatic pms_t mk_pms(input int m, input int p, input int s);
        return {M_W'(m), P_W'(p), S_W'(s)};
    endfunction

    function automatic pms_t lvl_pms(input lvl_idx_t idx);
        pms_t r;
        case (idx)
            5'd0:  r = mk_pms(625, 6, 0);
            5'd1:  r = mk_pms(500, 5, 0);
            5'd2:  r = mk_pms(575, 6, 0);
            5'd3:  r = mk_pms(550, 6, 0);
            5'd4:  r = mk_pms(350, 4, 0);
            5'd5:  r = mk_pms(500, 6, 0);
            5'd6:  r = mk_pms(475, 6, 0);
            5'd7:  r = mk_pms(375, 5, 0);
            5'd8:  r = mk_pms(425, 6, 0);
            5'd9:  r = mk_pms(400, 6, 0);
            5'd10: r = mk_pms(250, 4, 0);
            5'd11: r = mk_pms(350, 6, 0);
            5'd12: r = mk_pms(325, 6, 0);
            5'd13: r = mk_pms(500, 5, 1);
            5'd14: r = mk_pms(550, 6, 1);
            5'd15: r = mk_pms(500, 6, 1);
            5'd16: r = mk_pms(375, 5, 1);
            5'd17: r = mk_pms(400, 6, 1);
            5'd18: r = mk_pms(350, 6, 1);
            5'd19: r = mk_pms(500, 5, 2);
            5'd20: r = mk_pms(500, 6, 2);
            5'd21: r = mk_pms(400, 6, 2);
            5'd22: r = mk_pms(500, 5, 3);
            default: r = mk_pms(400, 6, 3);
        endcase
        return r;
    endfunction

    // Band of a level: 0 for the top ten, 1 for the next four, 2 below.
    function automatic int lvl_band(input lvl_idx_t idx);
        if (idx < lvl_idx_t'(10)) return 0;
        if (idx < lvl_idx_t'(14)) return 1;
        return 2;
    endfunction

    function automatic logic [DIVA_W-1:0] lvl_diva(input lvl_idx_t idx);
        logic [DIVA_W-1:0] w;
        w = '0;
        for (int f = 0; f < DIVA_N; f++) begin
            if (f == 2)
                w[f*DF_W +: DF_W] = DF_W'(4 - lvl_band(idx));
            else if (f >= 3)
                w[f*DF_W +: DF_W] = DF_W'(7);
        end
        return w;
    endfunction

    function automatic logic [DIVB_W-1:0] lvl_divb(input lvl_idx_t idx);
        logic [DIVB_W-1:0] w;
        w = '0;
        w[DF_W +: DF_W] = DF_W'(5 - lvl_band(idx));
        return w;
    endfunction

endpackage

// File: rtl/dvfs_level_rom.sv
module dvfs_level_rom
    import dvfs_pkg::*;
(
    input  lvl_idx_t             cfg_idx,
    input  lvl_idx_t             ref_idx,
    input  lvl_idx_t             div_idx,
    output pms_t                 cfg_pms,
    output logic                 same_mp,
    output logic [DIVA_W-1:0]    diva_word,
    output logic [DIVB_W-1:0]    divb_word
);
    pms_t ref_pms;

    always_comb begin
        cfg_pms   = lvl_pms(cfg_idx);
        ref_pms   = lvl_pms(ref_idx);
        same_mp   = (cfg_pms[PMS_W-1:S_W] == ref_pms[PMS_W-1:S_W]);
        diva_word = lvl_diva(div_idx);
        divb_word = lvl_divb(div_idx);
    end
endmodule

// File: rtl/dvfs_lock_timer.sv
module dvfs_lock_timer #(
    parameter int LOCK_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [LOCK_W-1:0] value,
    input  logic              start,
    output logic              locked
);
    typedef struct packed {
        logic [LOCK_W-1:0] limit;
        logic [LOCK_W-1:0] cnt;
        logic              run;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (set) begin
            t_d.limit = value;
            t_d.run   = 1'b0;
        end else if (start) begin
            t_d.cnt = '0;
            t_d.run = 1'b1;
        end else if (t_q.run && (t_q.cnt != t_q.limit)) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign locked = t_q.run && (t_q.cnt == t_q.limit);
endmodule

// File: rtl/dvfs_wait_guard.sv
module dvfs_wait_guard #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!waiting)
            cnt_d = '0;
        else if (cnt_q != {TMO_W{1'b1}})
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = waiting && (cnt_q >= limit);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int SAFE_LVL = 17,
    parameter int TMO_W    = 16,
    parameter int LOCK_MUL = 150
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [LVL_IDX_W-1:0] req_old,
    input  logic [LVL_IDX_W-1:0] req_new,
    input  logic [TMO_W-1:0]     tmo_limit,
    output logic                 diva_we,
    output logic [DIVA_W-1:0]    diva_data,
    input  logic [DIVA_N-1:0]    diva_busy,
    output logic                 divb_we,
    output logic [DIVB_W-1:0]    divb_data,
    input  logic [DIVB_N-1:0]    divb_busy,
    output logic                 mux_we,
    output logic                 mux_to_pll,
    input  logic [1:0]           mux_status,
    output logic                 pll_we,
    output logic                 pll_s_we,
    output logic [PMS_W-1:0]     pll_cfg,
    output logic                 done,
    output logic                 err
);
    localparam int LOCK_W = P_W + $clog2(LOCK_MUL + 1);

    typedef enum logic [4:0] {
        ST_IDLE, ST_START, ST_DA_WR, ST_DA_WT, ST_DB_WR, ST_DB_WT,
        ST_AFTER_PRE, ST_RELOCK, ST_MBK_WR, ST_MBK_WT, ST_LOCK_SET,
        ST_PMS_WR, ST_LOCK_WT, ST_MPL_WR, ST_MPL_WT, ST_RELOCK_END,
        ST_SONLY, ST_FINISH
    } st_e;

    typedef struct packed {
        st_e      state;
        st_e      ret;
        lvl_idx_t old_idx;
        lvl_idx_t new_idx;
        lvl_idx_t div_idx;
        logic     done;
        logic     err;
    } seq_t;

    seq_t s_d, s_q;

    pms_t              cfg_pms;
    logic              same_mp;
    logic [DIVA_W-1:0] diva_word;
    logic [DIVB_W-1:0] divb_word;
    logic              locked;
    logic              waiting;
    logic              tmo_hit;
    logic              faster;
    logic              safe;
    logic [LOCK_W-1:0] lock_val;

    dvfs_level_rom u_rom (
        .cfg_idx   (s_q.new_idx),
        .ref_idx   (s_q.old_idx),
        .div_idx   (s_q.div_idx),
        .cfg_pms   (cfg_pms),
        .same_mp   (same_mp),
        .diva_word (diva_word),
        .divb_word (divb_word)
    );

    assign lock_val = LOCK_W'(cfg_pms[S_W +: P_W]) * LOCK_W'(LOCK_MUL);

    dvfs_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (s_q.state == ST_LOCK_SET),
        .value  (lock_val),
        .start  (s_q.state == ST_PMS_WR),
        .locked (locked)
    );

    assign waiting = s_q.state inside {ST_DA_WT, ST_DB_WT, ST_MBK_WT, ST_LOCK_WT, ST_MPL_WT};

    dvfs_wait_guard #(.TMO_W(TMO_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .waiting (waiting),
        .limit   (tmo_limit),
        .expired (tmo_hit)
    );

    assign faster = s_q.new_idx < s_q.old_idx;
    assign safe   = (s_q.old_idx < lvl_idx_t'(SAFE_LVL)) && (s_q.new_idx < lvl_idx_t'(SAFE_LVL));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.old_idx = req_old;
                    s_d.new_idx = req_new;
                    s_d.state   = (req_old == req_new) ? ST_FINISH : ST_START;
                end
            end
            ST_START: begin
                if (faster) begin
                    s_d.div_idx = s_q.new_idx;
                    s_d.ret     = ST_AFTER_PRE;
                    s_d.state   = ST_DA_WR;
                end else begin
                    s_d.state = same_mp ? ST_SONLY : ST_RELOCK;
                end
            end
            ST_DA_WR: s_d.state = ST_DA_WT;
            ST_DA_WT: begin
                if (diva_busy == '0) s_d.state = ST_DB_WR;
                else if (tmo_hit) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            ST_DB_WR: s_d.state = ST_DB_WT;
            ST_DB_WT: begin
                if (divb_busy == '0) s_d.state = s_q.ret;
                else if (tmo_hit) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            ST_AFTER_PRE: s_d.state = same_mp ? ST_SONLY : ST_RELOCK;
            ST_RELOCK: begin
                if (safe) begin
                    s_d.div_idx = lvl_idx_t'(SAFE_LVL);
                    s_d.ret     = ST_MBK_WR;
                    s_d.state   = ST_DA_WR;
                end else begin
                    s_d.state = ST_MBK_WR;
                end
            end
            ST_MBK_WR: s_d.state = ST_MBK_WT;
            ST_MBK_WT: begin
                if (mux_status == MUX_CODE_BUS) s_d.state = ST_LOCK_SET;
                else if (tmo_hit) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            ST_LOCK_SET: s_d.state = ST_PMS_WR;
            ST_PMS_WR:   s_d.state = ST_LOCK_WT;
            ST_LOCK_WT: begin
                if (locked) s_d.state = ST_MPL_WR;
                else if (tmo_hit) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            ST_MPL_WR: s_d.state = ST_MPL_WT;
            ST_MPL_WT: begin
                if (mux_status == MUX_CODE_PLL) begin
                    if (safe) begin
                        s_d.div_idx = s_q.new_idx;
                        s_d.ret     = ST_RELOCK_END;
                        s_d.state   = ST_DA_WR;
                    end else begin
                        s_d.state = ST_RELOCK_END;
                    end
                end else if (tmo_hit) begin
                    s_d.err   = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end
            ST_RELOCK_END, ST_SONLY: begin
                if (faster) begin
                    s_d.state = ST_FINISH;
                end else begin
                    s_d.div_idx = s_q.new_idx;
                    s_d.ret     = ST_FINISH;
                    s_d.state   = ST_DA_WR;
                end
            end
            ST_FINISH: begin
                s_d.done  = 1'b1;
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.ret   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.state == ST_IDLE);
    assign diva_we    = (s_q.state == ST_DA_WR);
    assign diva_data  = diva_word;
    assign divb_we    = (s_q.state == ST_DB_WR);
    assign divb_data  = divb_word;
    assign mux_we     = (s_q.state == ST_MBK_WR) || (s_q.state == ST_MPL_WR);
    assign mux_to_pll = (s_q.state == ST_MPL_WR);
    assign pll_we     = (s_q.state == ST_PMS_WR);
    assign pll_s_we   = (s_q.state == ST_SONLY);
    assign pll_cfg    = cfg_pms;
    assign done       = s_q.done;
    assign err        = s_q.err;
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk
    import dvfs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              diva_we,
    input logic [DIVA_N-1:0] diva_busy,
    input logic              divb_we,
    input logic              mux_we,
    input logic [1:0]        mux_status,
    input logic              pll_we,
    input logic              pll_s_we,
    input logic              done,
    input logic              err
);
    // R6: at most one write strobe per cycle
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({diva_we, divb_we, mux_we, pll_we, pll_s_we}));

    // R6: group B written only after group A reported all flags clear
    p_divb_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        divb_we |-> ($past(diva_busy) == '0));

    // R7: full PLL write only while parked on the backup clock
    p_pms_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_we |-> ($past(mux_status, 2) == MUX_CODE_BUS));

    // R10: idle means no strobes
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(diva_we || divb_we || mux_we || pll_we || pll_s_we));

    // R11: done is a single-cycle pulse seen while idle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    // R12: error flag is sticky
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

bind dvfs_seq dvfs_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .diva_we    (diva_we),
    .diva_busy  (diva_busy),
    .divb_we    (divb_we),
    .mux_we     (mux_we),
    .mux_status (mux_status),
    .pll_we     (pll_we),
    .pll_s_we   (pll_s_we),
    .done       (done),
    .err        (err)
);

// File: tb/dvfs_seq_tb.sv
module dvfs_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_old = '0;
    logic [4:0]  req_new = '0;
    logic [15:0] tmo_limit = 16'd4000;
    logic        diva_we, divb_we, mux_we, mux_to_pll, pll_we, pll_s_we, done, err;
    logic [17:0] diva_data;
    logic [5:0]  diva_busy;
    logic [5:0]  divb_data;
    logic [1:0]  divb_busy;
    logic [1:0]  mux_status;
    logic [18:0] pll_cfg;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dvfs_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_old(req_old), .req_new(req_new), .tmo_limit(tmo_limit),
        .diva_we(diva_we), .diva_data(diva_data), .diva_busy(diva_busy),
        .divb_we(divb_we), .divb_data(divb_data), .divb_busy(divb_busy),
        .mux_we(mux_we), .mux_to_pll(mux_to_pll), .mux_status(mux_status),
        .pll_we(pll_we), .pll_s_we(pll_s_we), .pll_cfg(pll_cfg),
        .done(done), .err(err)
    );

    // ---------------- status responders ----------------
    int  da_cnt = 0, db_cnt = 0, mx_cnt = 0;
    logic [1:0] mx_tgt = 2'd1;
    logic [1:0] mx_stat = 2'd1;
    bit  stall = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            da_cnt <= 0; db_cnt <= 0; mx_cnt <= 0; mx_stat <= 2'd1;
        end else begin
            if (diva_we) da_cnt <= 1 + int'($urandom % 4);
            else if (da_cnt != 0) da_cnt <= da_cnt - 1;
            if (divb_we) db_cnt <= 1 + int'($urandom % 4);
            else if (db_cnt != 0) db_cnt <= db_cnt - 1;
            if (mux_we) begin
                mx_cnt  <= 1 + int'($urandom % 3);
                mx_tgt  <= mux_to_pll ? 2'd1 : 2'd2;
                mx_stat <= 2'd0;
            end else if (mx_cnt != 0) begin
                mx_cnt <= mx_cnt - 1;
                if (mx_cnt == 1 && !stall) mx_stat <= mx_tgt;
            end
        end
    end

    assign diva_busy  = (da_cnt > 1) ? 6'h3F : (da_cnt == 1) ? 6'h20 : 6'h00;
    assign divb_busy  = (db_cnt > 1) ? 2'b11 : (db_cnt == 1) ? 2'b10 : 2'b00;
    assign mux_status = mx_stat;

    // ---------------- reference model ----------------
    function automatic int b_pms(input int i);
        int m, p, s;
        case (i)
            0: begin m=625; p=6; s=0; end   1: begin m=500; p=5; s=0; end
            2: begin m=575; p=6; s=0; end   3: begin m=550; p=6; s=0; end
            4: begin m=350; p=4; s=0; end   5: begin m=500; p=6; s=0; end
            6: begin m=475; p=6; s=0; end   7: begin m=375; p=5; s=0; end
            8: begin m=425; p=6; s=0; end   9: begin m=400; p=6; s=0; end
            10: begin m=250; p=4; s=0; end  11: begin m=350; p=6; s=0; end
            12: begin m=325; p=6; s=0; end  13: begin m=500; p=5; s=1; end
            14: begin m=550; p=6; s=1; end  15: begin m=500; p=6; s=1; end
            16: begin m=375; p=5; s=1; end  17: begin m=400; p=6; s=1; end
            18: begin m=350; p=6; s=1; end  19: begin m=500; p=5; s=2; end
            20: begin m=500; p=6; s=2; end  21: begin m=400; p=6; s=2; end
            22: begin m=500; p=5; s=3; end  default: begin m=400; p=6; s=3; end
        endcase
        return (m << 9) | (p << 3) | s;
    endfunction

    function automatic int b_band(input int i);
        return (i < 10) ? 0 : (i < 14) ? 1 : 2;
    endfunction
    function automatic int b_diva(input int i);
        return (7 << 15) | (7 << 12) | (7 << 9) | ((4 - b_band(i)) << 6);
    endfunction
    function automatic int b_divb(input int i);
        return (5 - b_band(i)) << 3;
    endfunction

    // event kinds: 1 div A, 2 div B, 3 mux to bus, 4 mux to PLL, 5 full PLL, 6 S only
    int exp_k[32], exp_d[32], exp_n;
    int ev_k[32],  ev_d[32],  ev_n;

    task automatic push_exp(input int k, input int d);
        if (exp_n < 32) begin exp_k[exp_n] = k; exp_d[exp_n] = d; end
        exp_n++;
    endtask
    task automatic exp_div(input int i);
        push_exp(1, b_diva(i));
        push_exp(2, b_divb(i));
    endtask
    task automatic exp_relock(input int o, input int nw);
        bit sf;
        sf = (o < 17) && (nw < 17);
        if (sf) exp_div(17);
        push_exp(3, 0);
        push_exp(5, b_pms(nw));
        push_exp(4, 0);
        if (sf) exp_div(nw);
    endtask
    task automatic build_exp(input int o, input int nw);
        bit so;
        exp_n = 0;
        if (o == nw) return;
        so = (b_pms(o) >> 3) == (b_pms(nw) >> 3);
        if (nw < o) begin
            exp_div(nw);
            if (so) push_exp(6, b_pms(nw) & 7); else exp_relock(o, nw);
        end else begin
            if (so) push_exp(6, b_pms(nw) & 7); else exp_relock(o, nw);
            exp_div(nw);
        end
    endtask

    // ---------------- monitor ----------------
    bit  logging = 1'b0;
    int  cyc = 0, t_pms = 0, t_back = 0, order_bad = 0;
    logic [5:0] prev_busy_a = '0;

    task automatic push_ev(input int k, input int d);
        if (ev_n < 32) begin ev_k[ev_n] = k; ev_d[ev_n] = d; end
        ev_n++;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (logging) begin
            if (diva_we) push_ev(1, int'(diva_data));
            if (divb_we) begin
                push_ev(2, int'(divb_data));
                if (prev_busy_a != 0) order_bad++;
            end
            if (mux_we && !mux_to_pll) push_ev(3, 0);
            if (mux_we && mux_to_pll) begin push_ev(4, 0); t_back = cyc; end
            if (pll_we) begin push_ev(5, int'(pll_cfg)); t_pms = cyc; end
            if (pll_s_we) push_ev(6, int'(pll_cfg[2:0]));
        end
        prev_busy_a = diva_busy;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // mode 0 normal, 1 lock wait times out, 2 mux never answers
    task automatic run_req(input int o, input int nw, input int mode);
        bit got_done, fin, relock;
        int k_end, p;
        build_exp(o, nw);
        relock = (o != nw) && ((b_pms(o) >> 3) != (b_pms(nw) >> 3));
        if (mode != 0) begin
            k_end = 0;
            for (int i = 0; i < exp_n && i < 32; i++)
                if (exp_k[i] == ((mode == 1) ? 5 : 3)) begin k_end = i + 1; break; end
            exp_n = k_end;
        end
        ev_n = 0; order_bad = 0; got_done = 0; fin = 0;
        logging = 1'b1;
        req_valid = 1'b1; req_old = 5'(o); req_new = 5'(nw);
        @(negedge clk);
        if (relock && mode == 0) begin
            req_old = 5'd0; req_new = 5'd23;
            for (int j = 0; j < 4; j++) begin
                check(req_ready == 1'b0, "R10 busy not ready", int'(req_ready), 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        for (int w = 0; w < 30000; w++) begin
            if (done) got_done = 1;
            if ((mode == 0 && done) || (mode != 0 && err && req_ready)) begin fin = 1; break; end
            @(negedge clk);
        end
        check(fin, "R11 sequence finished", int'(fin), 1);
        repeat (6) begin
            if (done) got_done = 1;
            @(negedge clk);
        end
        logging = 1'b0;
        if (mode == 0) check(got_done, "R11 done pulse", int'(got_done), 1);
        else begin
            check(!got_done, "R12 no done after timeout", int'(got_done), 0);
            check(err == 1'b1, "R12 err set", int'(err), 1);
            check(req_ready == 1'b1, "R12 back to idle", int'(req_ready), 1);
        end
        check(ev_n == exp_n, "R3 R4 R5 R7 R8 step count", ev_n, exp_n);
        for (int i = 0; i < exp_n && i < ev_n && i < 32; i++) begin
            check(ev_k[i] == exp_k[i], "R4 R5 R7 R8 step kind", ev_k[i], exp_k[i]);
            check(ev_d[i] == exp_d[i], "R1 R3 R6 step data", ev_d[i], exp_d[i]);
        end
        check(order_bad == 0, "R6 group A clear before B", order_bad, 0);
        if (relock && mode == 0) begin
            p = (b_pms(nw) >> 3) & 63;
            check(t_back - t_pms == p * 150 + 2, "R9 lock window", t_back - t_pms, p * 150 + 2);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(err == 1'b0, "R1 err", int'(err), 0);
        check({diva_we, divb_we, mux_we, pll_we, pll_s_we} == 5'b0, "R1 strobes", 0, 0);

        // directed corners
        run_req(3, 3, 0);    // R2 equal indices
        check(ev_n == 0, "R2 no strobes", ev_n, 0);
        run_req(1, 13, 0);   // R3 R5 slower, S only
        run_req(13, 1, 0);   // R3 R4 faster, S only
        run_req(5, 3, 0);    // R8 faster with safe bracket
        run_req(3, 5, 0);    // R8 slower with safe bracket
        run_req(20, 2, 0);   // R4 relock from below safe level
        run_req(2, 20, 0);   // R5 relock into slow range
        run_req(17, 16, 0);  // R7 old at safe level, no bracket
        run_req(23, 0, 0);
        run_req(0, 23, 0);

        // random pairs
        for (int n = 0; n < 36; n++) begin
            int o, nw;
            o  = int'($urandom % 24);
            nw = int'($urandom % 24);
            run_req(o, nw, 0);
        end

        // R12 timeout during lock wait, then sticky across a good request
        tmo_limit = 16'd100;
        run_req(5, 3, 1);
        tmo_limit = 16'd4000;
        run_req(3, 9, 0);
        check(err == 1'b1, "R12 err sticky", int'(err), 1);
        do_reset();
        check(err == 1'b0, "R1 err cleared by reset", int'(err), 0);

        // R12 mux never reports its target
        tmo_limit = 16'd300;
        stall = 1'b1;
        run_req(2, 20, 2);
        stall = 1'b0;
        do_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(10 * 190000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule